// File: doc/BRIEF.md
# Chained FIFO Segments with Token Hand-off

This block builds one deep first-in, first-out buffer out of two to four equal storage segments that share one clock. Two tokens travel around a ring of segments: the segment holding the write token stores incoming words, and the segment holding the read token supplies outgoing words. When a segment stores into its final physical slot, it sends a registered one-clock pulse on its write-pass output to the next segment's write-pass input. That segment takes over the write token on the following edge. Reads move around the ring the same way through a separate read-pass pair. The last segment's pass outputs return to the first segment, which closes the ring.

Each segment has a first-segment strap. It is low on the first segment and high on the others, and it decides which segment starts with both tokens after reset. When only one segment is built, its strap and both pass inputs are tied low. That segment then keeps both tokens permanently, and its dual-purpose pass output reports half-full in place of the write pulse. The block-level empty and full are formed from every segment's own flag, and the output mux shows the word from the segment that holds the read token. Reads are first-word-fall-through: the oldest word is on `rd_data` whenever `rd_valid` is high.

Top module: `fifo_chain`

## Requirements
- R1: While reset is high and on the cycle after it is released, `empty`=1, `rd_valid`=0, `full`=0, and the first segment holds both tokens.
- R2: Words leave in the order they were accepted. A word is accepted on a rising edge where `wr_en`=1 and `full`=0.
- R3: With no reads, `full` stays at 1 once SEGS*DEPTH words are held. Writes attempted while `full`=1 store nothing, and draining afterwards returns only the accepted words.
- R4: A read attempted while `empty`=1 is ignored and moves no pointer. A word written afterwards is the one presented.
- R5: Writing a segment's last physical slot raises that segment's write-pass pulse for exactly one cycle. During that cycle `full`=1, and on the next edge the next segment in the ring owns the write token.
- R6: Reading a segment's last physical slot raises its read-pass pulse for exactly one cycle. During that cycle `empty`=1, and on the next edge the next segment owns the read token.
- R7: The last segment hands both tokens back to the first. Continuous simultaneous writing and reading keeps word order across several trips round the ring.
- R8: At no time does more than one segment hold the write token, and at no time does more than one hold the read token.
- R9: With SEGS=1 the single segment keeps both tokens permanently. Full and empty show no hand-off gap, and `half_full`=1 exactly when more than DEPTH/2 words are held.
- R10: With SEGS greater than 1, `half_full` stays 0.
- R11: `rd_valid`=1 exactly when `empty`=0, and `rd_data` then shows the oldest held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| full | output | 1 | No segment can accept a word this cycle |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Oldest word, taken from the read-token segment |
| rd_valid | output | 1 | `rd_data` holds a word |
| empty | output | 1 | No segment can supply a word this cycle |
| half_full | output | 1 | More than half full; stand-alone build only |

## Verification
The assertions check the following on every cycle:
- Each token is held by at most one segment.
- Each pass pulse lasts one cycle.
- The token lands on the next segment in the ring.
- The hand-off cycle shows as full or empty.
- Both tokens start at the first segment.

Only the bench's scenarios can show the following:
- Word order across segments and around the ring.
- Refused writes and ignored reads leave no trace.
- The exact cycle the hand-off stall appears and clears.
- The stand-alone build keeps its tokens and reports half-full at the right fill level.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;

    localparam int MAX_SEGS = 4;

    // Per-segment status carried from each segment to the combining logic.
    typedef struct packed {
        logic wr_tok;   // segment owns the write token
        logic rd_tok;   // segment owns the read token
        logic wr_pass;  // registered hand-off pulse for the write token
        logic rd_pass;  // registered hand-off pulse for the read token
        logic can_wr;   // token held and room left
        logic can_rd;   // token held and a word present
    } seg_stat_t;

    // Token position after one step round a ring of n segments.
    function automatic logic [MAX_SEGS-1:0] ring_next(input logic [MAX_SEGS-1:0] v,
                                                       input int unsigned n);
        logic [MAX_SEGS-1:0] r;
        r = '0;
        for (int unsigned i = 0; i < n; i++) begin
            r[(i + 1) % n] = v[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/chain_token_ctl.sv
module chain_token_ctl #(
    parameter bit CHAINED = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic first_load,
    input  logic xi_wr,
    input  logic xi_rd,
    input  logic wr_last,
    input  logic rd_last,
    output logic wr_tok,
    output logic rd_tok,
    output logic xo_wr,
    output logic xo_rd
);

    generate
        if (CHAINED) begin : g_ring
            logic wtok_q, rtok_q, xo_wr_q, xo_rd_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    wtok_q  <= ~first_load;
                    rtok_q  <= ~first_load;
                    xo_wr_q <= 1'b0;
                    xo_rd_q <= 1'b0;
                end else begin
                    xo_wr_q <= wr_last;
                    xo_rd_q <= rd_last;
                    if (wr_last)    wtok_q <= 1'b0;
                    else if (xi_wr) wtok_q <= 1'b1;
                    if (rd_last)    rtok_q <= 1'b0;
                    else if (xi_rd) rtok_q <= 1'b1;
                end
            end

            assign wr_tok = wtok_q;
            assign rd_tok = rtok_q;
            assign xo_wr  = xo_wr_q;
            assign xo_rd  = xo_rd_q;
        end else begin : g_solo
            // Stand-alone: both tokens are owned for good, no pulses leave.
            assign wr_tok = 1'b1;
            assign rd_tok = 1'b1;
            assign xo_wr  = 1'b0;
            assign xo_rd  = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/chain_seg_mem.sv
module chain_seg_mem #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  logic                     pop,
    input  logic [WIDTH-1:0]         din,
    output logic [WIDTH-1:0]         dout,
    output logic                     wr_at_end,
    output logic                     rd_at_end,
    output logic [$clog2(DEPTH):0]   fill
);

    localparam int PW = $clog2(DEPTH);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PW-1:0]    wptr, rptr;
    logic [PW:0]      cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) store[wptr] <= din;
    end

    assign dout      = store[rptr];
    assign wr_at_end = (wptr == LAST);
    assign rd_at_end = (rptr == LAST);
    assign fill      = cnt;

endmodule

// File: rtl/chain_segment.sv
module chain_segment
    import fifo_chain_pkg::*;
#(
    parameter int WIDTH   = 18,
    parameter int DEPTH   = 4,
    parameter bit CHAINED = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             first_load,
    input  logic             xi_wr,
    input  logic             xi_rd,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             xo_hf,
    output seg_stat_t        stat
);

    localparam int FW = $clog2(DEPTH) + 1;

    logic          wr_tok, rd_tok, xo_wr, xo_rd;
    logic          push, pop, wr_at_end, rd_at_end;
    logic [FW-1:0] fill;
    logic          room, avail;

    assign room  = (fill != FW'(DEPTH));
    assign avail = (fill != '0);
    assign push  = wr_tok & wr_en & room;
    assign pop   = rd_tok & rd_en & avail;

    chain_token_ctl #(.CHAINED(CHAINED)) u_tok (
        .clk        (clk),
        .rst        (rst),
        .first_load (first_load),
        .xi_wr      (xi_wr),
        .xi_rd      (xi_rd),
        .wr_last    (push & wr_at_end),
        .rd_last    (pop & rd_at_end),
        .wr_tok     (wr_tok),
        .rd_tok     (rd_tok),
        .xo_wr      (xo_wr),
        .xo_rd      (xo_rd)
    );

    chain_seg_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .pop       (pop),
        .din       (din),
        .dout      (q),
        .wr_at_end (wr_at_end),
        .rd_at_end (rd_at_end),
        .fill      (fill)
    );

    // Dual-purpose output: write pulse when chained, half-full when alone.
    assign xo_hf = CHAINED ? xo_wr : (fill > FW'(DEPTH / 2));

    assign stat.wr_tok  = wr_tok;
    assign stat.rd_tok  = rd_tok;
    assign stat.wr_pass = xo_wr;
    assign stat.rd_pass = xo_rd;
    assign stat.can_wr  = wr_tok & room;
    assign stat.can_rd  = rd_tok & avail;

endmodule

// File: rtl/fifo_chain.sv
module fifo_chain
    import fifo_chain_pkg::*;
#(
    parameter int WIDTH = 18,
    parameter int DEPTH = 4,
    parameter int SEGS  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             full,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             empty,
    output logic             half_full
);

    localparam bit CHAINED = (SEGS > 1);

    seg_stat_t        stat   [SEGS];
    logic [WIDTH-1:0] seg_q  [SEGS];
    logic [SEGS-1:0]  seg_hf;
    logic [SEGS-1:0]  wr_tok_vec, rd_tok_vec, wxo_vec, rxo_vec, can_wr_vec, can_rd_vec;

    generate
        for (genvar i = 0; i < SEGS; i++) begin : g_seg
            localparam int  PREV = (i + SEGS - 1) % SEGS;
            localparam logic FL  = (CHAINED && i != 0);

            logic xi_wr, xi_rd;
            assign xi_wr = CHAINED ? wxo_vec[PREV] : 1'b0;
            assign xi_rd = CHAINED ? rxo_vec[PREV] : 1'b0;

            chain_segment #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CHAINED(CHAINED)) u_seg (
                .clk        (clk),
                .rst        (rst),
                .first_load (FL),
                .xi_wr      (xi_wr),
                .xi_rd      (xi_rd),
                .wr_en      (wr_en),
                .rd_en      (rd_en),
                .din        (wr_data),
                .q          (seg_q[i]),
                .xo_hf      (seg_hf[i]),
                .stat       (stat[i])
            );

            assign wr_tok_vec[i] = stat[i].wr_tok;
            assign rd_tok_vec[i] = stat[i].rd_tok;
            assign wxo_vec[i]    = stat[i].wr_pass;
            assign rxo_vec[i]    = stat[i].rd_pass;
            assign can_wr_vec[i] = stat[i].can_wr;
            assign can_rd_vec[i] = stat[i].can_rd;
        end
    endgenerate

    // Composite flags from every segment's own flag.
    assign full     = ~|can_wr_vec;
    assign empty    = ~|can_rd_vec;
    assign rd_valid = |can_rd_vec;

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < SEGS; i++) begin
            if (rd_tok_vec[i]) rd_data = seg_q[i];
        end
    end

    assign half_full = CHAINED ? 1'b0 : seg_hf[0];

endmodule

// File: rtl/fifo_chain_chk.sv
module fifo_chain_chk
    import fifo_chain_pkg::*;
#(
    parameter int SEGS = 3
) (
    input logic            clk,
    input logic            rst,
    input logic [SEGS-1:0] wr_tok_vec,
    input logic [SEGS-1:0] rd_tok_vec,
    input logic [SEGS-1:0] wxo_vec,
    input logic [SEGS-1:0] rxo_vec,
    input logic            full,
    input logic            empty
);

    assert_one_wr_token_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_tok_vec));

    assert_one_rd_token_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_tok_vec));

    assert_reset_tokens_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wr_tok_vec[0] && rd_tok_vec[0]));

    assert_wr_pulse_once_R5: assert property (@(posedge clk) disable iff (rst)
        (wxo_vec != '0) |=> (wxo_vec == '0));

    assert_wr_handoff_R5: assert property (@(posedge clk) disable iff (rst)
        (wxo_vec != '0) |=> (wr_tok_vec == SEGS'(ring_next(MAX_SEGS'($past(wxo_vec)), SEGS))));

    assert_wr_gap_full_R5: assert property (@(posedge clk) disable iff (rst)
        (wxo_vec != '0) |-> full);

    assert_rd_pulse_once_R6: assert property (@(posedge clk) disable iff (rst)
        (rxo_vec != '0) |=> (rxo_vec == '0));

    assert_rd_handoff_R6: assert property (@(posedge clk) disable iff (rst)
        (rxo_vec != '0) |=> (rd_tok_vec == SEGS'(ring_next(MAX_SEGS'($past(rxo_vec)), SEGS))));

    assert_rd_gap_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (rxo_vec != '0) |-> empty);

endmodule

bind fifo_chain fifo_chain_chk #(.SEGS(SEGS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_tok_vec (wr_tok_vec),
    .rd_tok_vec (rd_tok_vec),
    .wxo_vec    (wxo_vec),
    .rxo_vec    (rxo_vec),
    .full       (full),
    .empty      (empty)
);

// File: tb/tb_fifo_chain.sv
`timescale 1ns/1ps
module tb_fifo_chain;

    localparam int W = 18;
    localparam int D = 4;
    localparam int S = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         full, empty, rd_valid, half_full;

    logic         s_wr_en = 1'b0, s_rd_en = 1'b0;
    logic [W-1:0] s_wr_data = '0;
    logic [W-1:0] s_rd_data;
    logic         s_full, s_empty, s_rd_valid, s_hf;

    fifo_chain #(.WIDTH(W), .DEPTH(D), .SEGS(S)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(full),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty),
        .half_full(half_full)
    );

    fifo_chain #(.WIDTH(W), .DEPTH(D), .SEGS(1)) dut_solo (
        .clk(clk), .rst(rst), .wr_en(s_wr_en), .wr_data(s_wr_data), .full(s_full),
        .rd_en(s_rd_en), .rd_data(s_rd_data), .rd_valid(s_rd_valid), .empty(s_empty),
        .half_full(s_hf)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [W-1:0] model  [$];
    logic [W-1:0] smodel [$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One write attempt on the chained instance; called at a falling edge.
    task automatic wr1(input logic [W-1:0] d, output bit took);
        wr_en = 1'b1; wr_data = d;
        took = !full;
        if (took) model.push_back(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd1(output bit took);
        logic [W-1:0] exp;
        rd_en = 1'b1;
        took = !empty;
        if (took) begin
            exp = model.pop_front();
            chk(rd_data == exp, "R2 read order", int'(rd_data), int'(exp));
        end
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        chk(empty == 1'b1,    "R1 empty after reset", empty, 1);
        chk(full == 1'b0,     "R1 full after reset", full, 0);
        chk(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);
        chk(half_full == 1'b0, "R10 half_full chained", half_full, 0);
    endtask

    task automatic t_write_handoff;
        bit took;
        for (int i = 0; i < D; i++) begin
            wr1(W'(10 + i), took);
            chk(took, "R5 write accepted before hand-off", took, 1);
            chk(full == (i == D - 1), "R5 full during write hand-off", full, int'(i == D - 1));
        end
        @(negedge clk);
        chk(full == 1'b0, "R5 full clears after hand-off", full, 0);
        wr1(W'(14), took);
        wr1(W'(15), took);
        chk(took, "R5 next segment accepts", took, 1);
    endtask

    task automatic t_read_handoff;
        bit took;
        chk(rd_valid == 1'b1 && rd_data == W'(10), "R11 oldest word shown", int'(rd_data), 10);
        for (int i = 0; i < D; i++) rd1(took);
        chk(empty == 1'b1,    "R6 empty during read hand-off", empty, 1);
        chk(rd_valid == 1'b0, "R11 rd_valid low in gap", rd_valid, 0);
        @(negedge clk);
        chk(empty == 1'b0 && rd_data == W'(14), "R6 next segment supplies", int'(rd_data), 14);
        rd1(took);
        rd1(took);
        chk(empty == 1'b1, "R11 empty after drain", empty, 1);
    endtask

    task automatic t_empty_read;
        bit took;
        rd_en = 1'b1;
        repeat (3) @(negedge clk);
        rd_en = 1'b0;
        chk(empty == 1'b1, "R4 empty stays after ignored reads", empty, 1);
        wr1(W'(77), took);
        chk(rd_valid == 1'b1 && rd_data == W'(77), "R4 word after ignored reads", int'(rd_data), 77);
        rd1(took);
    endtask

    task automatic t_fill;
        bit took;
        int acc = 0;
        for (int i = 0; i < 40 && acc < S * D; i++) begin
            wr1(W'(200 + acc), took);
            if (took) acc++;
        end
        chk(acc == S * D, "R3 capacity accepted", acc, S * D);
        chk(half_full == 1'b0, "R10 half_full chained when full", half_full, 0);
        for (int i = 0; i < 5; i++) begin
            wr1(W'(999), took);
            chk(!took && full, "R3 full holds, write refused", full, 1);
        end
        for (int i = 0; i < 60 && model.size() > 0; i++) rd1(took);
        chk(model.size() == 0, "R3 all accepted words returned", model.size(), 0);
        repeat (2) @(negedge clk);
        chk(empty == 1'b1, "R3 no refused word stored", int'(rd_data), -1);
    endtask

    task automatic t_stream;
        bit wt, rt;
        int sent = 0;
        for (int i = 0; i < 60; i++) begin
            wr_en = 1'b1; wr_data = W'(500 + sent);
            rd_en = 1'b1;
            wt = !full; rt = !empty;
            if (rt) begin
                chk(rd_data == model[0], "R7 order while streaming", int'(rd_data), int'(model[0]));
                void'(model.pop_front());
            end
            if (wt) begin model.push_back(W'(500 + sent)); sent++; end
            @(negedge clk);
        end
        wr_en = 1'b0; rd_en = 1'b0;
        chk(sent > 2 * S * D, "R7 several trips round ring", sent, 2 * S * D);
        for (int i = 0; i < 60 && model.size() > 0; i++) rd1(wt);
        chk(model.size() == 0 && empty, "R7 stream drained", model.size(), 0);
    endtask

    task automatic s_wr(input logic [W-1:0] d);
        s_wr_en = 1'b1; s_wr_data = d;
        if (!s_full) smodel.push_back(d);
        @(negedge clk);
        s_wr_en = 1'b0;
    endtask

    task automatic s_rd;
        s_rd_en = 1'b1;
        if (!s_empty) begin
            chk(s_rd_data == smodel[0], "R9 solo order", int'(s_rd_data), int'(smodel[0]));
            void'(smodel.pop_front());
        end
        @(negedge clk);
        s_rd_en = 1'b0;
    endtask

    task automatic t_solo;
        for (int i = 0; i < D; i++) begin
            s_wr(W'(300 + i));
            chk(s_hf == (i + 1 > D / 2), "R9 half_full level", s_hf, int'(i + 1 > D / 2));
            chk(s_full == (i == D - 1), "R9 solo full without gap", s_full, int'(i == D - 1));
        end
        s_rd;
        chk(s_full == 1'b0, "R9 room right after read", s_full, 0);
        s_wr(W'(304));
        chk(s_full == 1'b1, "R9 token kept after last slot", s_full, 1);
        for (int i = 0; i < D; i++) begin
            chk(s_empty == 1'b0, "R9 read token kept", s_empty, 0);
            s_rd;
        end
        chk(s_empty == 1'b1 && smodel.size() == 0, "R9 solo drained", s_empty, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(empty == 1'b1 && full == 1'b0, "R1 flags during reset", empty, 1);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_write_handoff;
        t_read_handoff;
        t_empty_read;
        t_fill;
        t_stream;
        t_solo;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule